// File: doc/BRIEF.md
# DRAM Bank Command Timing Guard

This block sits beside the command path of a DDR3-style memory controller and watches one rank of eight banks. For the command currently offered (operation, bank address and the two sampled address bits A10 and A12) it says, in the same cycle, whether issuing that command now would meet every inter-command timing rule. It tracks each bank through idle, active, auto-precharge wait, closing and refreshing. Per-bank and rank-wide down-counters hold the age of recent commands.

All timing values are runtime configuration inputs in clock cycles and are assumed stable while commands flow. A command counts as issued on a rising edge where `cmdValid` is high. If it is legal, the bank state and counters advance. If it is illegal, a sticky error flag is raised and nothing else changes. In both cases the legality flags describe the command offered and the bank named on `cmdBank`, whether or not `cmdValid` is high. A spacing of N cycles means that a command issued in cycle t allows the dependent command in cycle t+N. A configured value of 0 behaves as 1.

Operation codes on `cmdOp`: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh; 6 and 7 are reserved.

Top module: `dram_timing_guard`

## Requirements
- R1: A read or write (op 2 or 3) to a bank is legal only when that bank is active and at least `cfgTrcd` cycles have passed since its activate.
- R2: Two activates to the same bank are at least `cfgTras`+`cfgTrp` cycles apart. Activates to different banks are at least `cfgTrrd` cycles apart.
- R3: Only one row per bank may be open. An activate to an active bank is illegal. After a precharge of that bank, an activate becomes legal exactly `cfgTrp` cycles later.
- R4: A precharge (op 4) with `cmdA10`=1 closes every active bank. With `cmdA10`=0 it closes only the bank on `cmdBank`. It is legal on an active bank only once `cfgTras` cycles have passed since the activate and `cfgTrtp` cycles since the last read. A precharge of an already idle bank is legal and has no effect.
- R5: A refresh (op 5) is legal only when every bank is idle with `cfgTrp` satisfied and no refresh is in progress. After a refresh, no activate and no refresh is legal for `cfgTrfc` cycles, and then all banks report idle.
- R6: A read or write with `cmdA10`=1 requests auto-precharge. The bank stays open until `cfgTras` has elapsed since its activate and `cfgTrtp` has elapsed since its last read. It then closes, and an activate is legal `cfgTrp` cycles after closing starts. No column command is legal while it waits.
- R7: Column commands to any banks are at least 4 cycles apart. With `cmdA12`=1 (burst chop of 4) the spacing stays the same. `lastColChop` shows the A12 value of the most recent accepted column command.
- R8: A command with `cmdValid` high that is illegal, including reserved op codes, sets `cmdError`. The flag stays set until reset, and bank state and counters are left unchanged.
- R9: After reset all banks are idle and closed, `cmdError` and `lastColChop` are 0, and activate, refresh and precharge-all are legal while column commands are not.
- R10: `bankOpen[b]` is high while bank b holds an open row, including the auto-precharge wait. `bankIdle[b]` is high when bank b is precharged and available for an activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgTrcd | input | TIMER_W | Activate to column command, cycles |
| cfgTrp | input | TIMER_W | Precharge duration, cycles |
| cfgTras | input | TIMER_W | Activate to precharge minimum, cycles |
| cfgTrrd | input | TIMER_W | Activate to activate on different banks, cycles |
| cfgTrtp | input | TIMER_W | Read to precharge, cycles |
| cfgTrfc | input | TIMER_W | Refresh duration, cycles |
| cmdValid | input | 1 | Command is issued this cycle |
| cmdOp | input | 3 | Operation code |
| cmdBank | input | BANK_W | Bank address |
| cmdA10 | input | 1 | Sampled A10: all-bank precharge or auto-precharge |
| cmdA12 | input | 1 | Sampled A12: burst chop on column commands |
| okAct | output | 1 | Activate to cmdBank legal now |
| okCol | output | 1 | Read/write (with or without auto-precharge) to cmdBank legal now |
| okPre | output | 1 | Single-bank precharge of cmdBank legal now |
| okPreAll | output | 1 | All-bank precharge legal now |
| okRef | output | 1 | Refresh legal now |
| bankOpen | output | NUM_BANKS | Per-bank open-row status |
| bankIdle | output | NUM_BANKS | Per-bank idle-and-available status |
| lastColChop | output | 1 | A12 of the last accepted column command |
| cmdError | output | 1 | Sticky illegal-command flag |

## Verification
A counter that is loaded one cycle short or long moves a legal flag edge by one cycle. The bench therefore probes each flag in the cycle just before its boundary and in the boundary cycle itself. A bank state that goes wrong shows on `bankOpen` or `bankIdle` in the cycle right after the offending edge. It also shows later as a column or activate permission that appears or vanishes at the wrong time. An illegal command that leaks into the state reveals itself at the next probe of the same bank, where an open bank would read closed or would lose column access.

// File: rtl/dram_guard_pkg.sv
package dram_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ACT   = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_PRE   = 3'd4,
    OP_REF   = 3'd5
  } cmd_op_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_ACTIVE,
    BK_APWAIT,
    BK_CLOSING,
    BK_REFRESH
  } bank_state_e;

  // rank-wide load strobes from control to the counter datapath
  typedef struct packed {
    logic rrdLoad;
    logic ccdLoad;
    logic rfcLoad;
  } glob_strobe_t;

  localparam int CCD_CYCLES = 4;

endpackage

// File: rtl/guard_dpath.sv
module guard_dpath
  import dram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TIMER_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TIMER_W-1:0]   cfgTrcd,
  input  logic [TIMER_W-1:0]   cfgTrp,
  input  logic [TIMER_W-1:0]   cfgTras,
  input  logic [TIMER_W-1:0]   cfgTrrd,
  input  logic [TIMER_W-1:0]   cfgTrtp,
  input  logic [TIMER_W-1:0]   cfgTrfc,
  input  glob_strobe_t         strobe,
  input  logic [NUM_BANKS-1:0] actHit,
  input  logic [NUM_BANKS-1:0] readHit,
  input  logic [NUM_BANKS-1:0] closeStart,
  output logic [NUM_BANKS-1:0] rcdZero,
  output logic [NUM_BANKS-1:0] rasZero,
  output logic [NUM_BANKS-1:0] rcZero,
  output logic [NUM_BANKS-1:0] rpZero,
  output logic [NUM_BANKS-1:0] rtpZero,
  output logic                 rrdZero,
  output logic                 ccdZero,
  output logic                 rfcZero
);

  localparam int CCD_W = $clog2(CCD_CYCLES + 1);

  // a spacing of N cycles is a reload of N-1; zero behaves as one
  function automatic logic [TIMER_W-1:0] reloadOf(input logic [TIMER_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [TIMER_W:0] reloadWide(input logic [TIMER_W:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [TIMER_W:0] rcSpan;
  assign rcSpan = {1'b0, cfgTras} + {1'b0, cfgTrp};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TIMER_W-1:0] rcdCnt, rasCnt, rpCnt, rtpCnt;
    logic [TIMER_W:0]   rcCnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rcdCnt <= '0;
        rasCnt <= '0;
        rcCnt  <= '0;
        rpCnt  <= '0;
        rtpCnt <= '0;
      end else begin
        rcdCnt <= actHit[b]     ? reloadOf(cfgTrcd) : (rcdCnt != '0 ? rcdCnt - 1'b1 : rcdCnt);
        rasCnt <= actHit[b]     ? reloadOf(cfgTras) : (rasCnt != '0 ? rasCnt - 1'b1 : rasCnt);
        rcCnt  <= actHit[b]     ? reloadWide(rcSpan) : (rcCnt != '0 ? rcCnt - 1'b1 : rcCnt);
        rpCnt  <= closeStart[b] ? reloadOf(cfgTrp)  : (rpCnt != '0 ? rpCnt - 1'b1 : rpCnt);
        rtpCnt <= readHit[b]    ? reloadOf(cfgTrtp) : (rtpCnt != '0 ? rtpCnt - 1'b1 : rtpCnt);
      end
    end

    assign rcdZero[b] = (rcdCnt == '0);
    assign rasZero[b] = (rasCnt == '0);
    assign rcZero[b]  = (rcCnt == '0);
    assign rpZero[b]  = (rpCnt == '0);
    assign rtpZero[b] = (rtpCnt == '0);

    // R1: an activate with tRCD above one must block column access next cycle
    a_r1_rcd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (actHit[b] && cfgTrcd > 1) |=> !rcdZero[b]);
  end

  logic [TIMER_W-1:0] rrdCnt, rfcCnt;
  logic [CCD_W-1:0]   ccdCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrdCnt <= '0;
      rfcCnt <= '0;
      ccdCnt <= '0;
    end else begin
      rrdCnt <= strobe.rrdLoad ? reloadOf(cfgTrrd) : (rrdCnt != '0 ? rrdCnt - 1'b1 : rrdCnt);
      rfcCnt <= strobe.rfcLoad ? reloadOf(cfgTrfc) : (rfcCnt != '0 ? rfcCnt - 1'b1 : rfcCnt);
      ccdCnt <= strobe.ccdLoad ? CCD_W'(CCD_CYCLES - 1) : (ccdCnt != '0 ? ccdCnt - 1'b1 : ccdCnt);
    end
  end

  assign rrdZero = (rrdCnt == '0);
  assign rfcZero = (rfcCnt == '0);
  assign ccdZero = (ccdCnt == '0);

  a_r7_ccd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ccdLoad |=> !ccdZero);

  a_r5_rfc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rfcLoad && cfgTrfc > 1) |=> !rfcZero);

endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import dram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 cmdA10,
  input  logic                 cmdA12,
  input  logic [NUM_BANKS-1:0] rcdZero,
  input  logic [NUM_BANKS-1:0] rasZero,
  input  logic [NUM_BANKS-1:0] rcZero,
  input  logic [NUM_BANKS-1:0] rpZero,
  input  logic [NUM_BANKS-1:0] rtpZero,
  input  logic                 rrdZero,
  input  logic                 ccdZero,
  input  logic                 rfcZero,
  output glob_strobe_t         strobe,
  output logic [NUM_BANKS-1:0] actHit,
  output logic [NUM_BANKS-1:0] readHit,
  output logic [NUM_BANKS-1:0] closeStart,
  output logic                 okAct,
  output logic                 okCol,
  output logic                 okPre,
  output logic                 okPreAll,
  output logic                 okRef,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankIdle,
  output logic                 lastColChop,
  output logic                 cmdError
);

  cmd_op_e op;
  assign op = cmd_op_e'(cmdOp);

  logic [NUM_BANKS-1:0] isReady, isActive, canPre;
  logic legal, issue;
  logic actIss, rdIss, wrIss, preIss, refIss;

  always_comb begin
    okAct    = isReady[cmdBank] && rcZero[cmdBank] && rrdZero && rfcZero;
    okCol    = isActive[cmdBank] && rcdZero[cmdBank] && ccdZero;
    okPre    = canPre[cmdBank];
    okPreAll = &canPre;
    okRef    = (&isReady) && rfcZero;
    unique case (op)
      OP_NOP:            legal = 1'b1;
      OP_ACT:            legal = okAct;
      OP_READ, OP_WRITE: legal = okCol;
      OP_PRE:            legal = cmdA10 ? okPreAll : okPre;
      OP_REF:            legal = okRef;
      default:           legal = 1'b0;
    endcase
  end

  assign issue  = cmdValid && legal;
  assign actIss = issue && (op == OP_ACT);
  assign rdIss  = issue && (op == OP_READ);
  assign wrIss  = issue && (op == OP_WRITE);
  assign preIss = issue && (op == OP_PRE);
  assign refIss = issue && (op == OP_REF);

  assign strobe.rrdLoad = actIss;
  assign strobe.ccdLoad = rdIss || wrIss;
  assign strobe.rfcLoad = refIss;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_state_e st;
    logic hit, colApHit;

    assign hit        = (cmdBank == BANK_W'(b));
    assign colApHit   = (rdIss || wrIss) && hit && cmdA10;
    assign actHit[b]  = actIss && hit;
    assign readHit[b] = rdIss && hit;
    assign closeStart[b] = (preIss && (cmdA10 || hit) && st == BK_ACTIVE)
                        || (st == BK_APWAIT && rasZero[b] && rtpZero[b]);

    assign isActive[b] = (st == BK_ACTIVE);
    assign isReady[b]  = (st == BK_IDLE)
                      || (st == BK_CLOSING && rpZero[b])
                      || (st == BK_REFRESH && rfcZero);
    assign canPre[b]   = isReady[b] || (isActive[b] && rasZero[b] && rtpZero[b]);
    assign bankOpen[b] = (st == BK_ACTIVE) || (st == BK_APWAIT);
    assign bankIdle[b] = isReady[b];

    always_ff @(posedge clk) begin
      if (!rst_n)                          st <= BK_IDLE;
      else if (actHit[b])                  st <= BK_ACTIVE;
      else if (colApHit)                   st <= BK_APWAIT;
      else if (closeStart[b])              st <= BK_CLOSING;
      else if (refIss)                     st <= BK_REFRESH;
      else if (st == BK_CLOSING && rpZero[b]) st <= BK_IDLE;
      else if (st == BK_REFRESH && rfcZero)   st <= BK_IDLE;
    end

    // R3: an accepted activate opens the row on the next cycle
    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      actHit[b] |=> bankOpen[b]);

    // R6: an auto-precharge wait only ever leads to closing
    a_r6_ap_path: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BK_APWAIT) |=> (st == BK_APWAIT || st == BK_CLOSING));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdError    <= 1'b0;
      lastColChop <= 1'b0;
    end else begin
      if (cmdValid && !legal) cmdError <= 1'b1;
      if (rdIss || wrIss)     lastColChop <= cmdA12;
    end
  end

  a_r5_ref_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rfcLoad |=> (bankOpen == '0));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmdError |=> cmdError);

endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard
  import dram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TIMER_W   = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TIMER_W-1:0]   cfgTrcd,
  input  logic [TIMER_W-1:0]   cfgTrp,
  input  logic [TIMER_W-1:0]   cfgTras,
  input  logic [TIMER_W-1:0]   cfgTrrd,
  input  logic [TIMER_W-1:0]   cfgTrtp,
  input  logic [TIMER_W-1:0]   cfgTrfc,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 cmdA10,
  input  logic                 cmdA12,
  output logic                 okAct,
  output logic                 okCol,
  output logic                 okPre,
  output logic                 okPreAll,
  output logic                 okRef,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankIdle,
  output logic                 lastColChop,
  output logic                 cmdError
);

  glob_strobe_t         strobe;
  logic [NUM_BANKS-1:0] actHit, readHit, closeStart;
  logic [NUM_BANKS-1:0] rcdZero, rasZero, rcZero, rpZero, rtpZero;
  logic                 rrdZero, ccdZero, rfcZero;

  guard_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdA10(cmdA10), .cmdA12(cmdA12),
    .rcdZero(rcdZero), .rasZero(rasZero), .rcZero(rcZero),
    .rpZero(rpZero), .rtpZero(rtpZero),
    .rrdZero(rrdZero), .ccdZero(ccdZero), .rfcZero(rfcZero),
    .strobe(strobe), .actHit(actHit), .readHit(readHit), .closeStart(closeStart),
    .okAct(okAct), .okCol(okCol), .okPre(okPre), .okPreAll(okPreAll), .okRef(okRef),
    .bankOpen(bankOpen), .bankIdle(bankIdle),
    .lastColChop(lastColChop), .cmdError(cmdError)
  );

  guard_dpath #(.NUM_BANKS(NUM_BANKS), .TIMER_W(TIMER_W)) u_dpath (
    .clk(clk), .rst_n(rst_n),
    .cfgTrcd(cfgTrcd), .cfgTrp(cfgTrp), .cfgTras(cfgTras),
    .cfgTrrd(cfgTrrd), .cfgTrtp(cfgTrtp), .cfgTrfc(cfgTrfc),
    .strobe(strobe), .actHit(actHit), .readHit(readHit), .closeStart(closeStart),
    .rcdZero(rcdZero), .rasZero(rasZero), .rcZero(rcZero),
    .rpZero(rpZero), .rtpZero(rtpZero),
    .rrdZero(rrdZero), .ccdZero(ccdZero), .rfcZero(rfcZero)
  );

endmodule

// File: tb/tb_dram_timing_guard.sv
module tb_dram_timing_guard;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, REF = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfgTrcd = 8'd3, cfgTrp = 8'd3, cfgTras = 8'd8;
  logic [7:0] cfgTrrd = 8'd2, cfgTrtp = 8'd2, cfgTrfc = 8'd10;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = NOP;
  logic [2:0] cmdBank = '0;
  logic cmdA10 = 1'b0, cmdA12 = 1'b0;
  logic okAct, okCol, okPre, okPreAll, okRef, lastColChop, cmdError;
  logic [7:0] bankOpen, bankIdle;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dram_timing_guard dut (
    .clk(clk), .rst_n(rst_n),
    .cfgTrcd(cfgTrcd), .cfgTrp(cfgTrp), .cfgTras(cfgTras),
    .cfgTrrd(cfgTrrd), .cfgTrtp(cfgTrtp), .cfgTrfc(cfgTrfc),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdA10(cmdA10), .cmdA12(cmdA12),
    .okAct(okAct), .okCol(okCol), .okPre(okPre), .okPreAll(okPreAll), .okRef(okRef),
    .bankOpen(bankOpen), .bankIdle(bankIdle),
    .lastColChop(lastColChop), .cmdError(cmdError)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, outputs settle before the rising edge
  task automatic step(input logic v, input logic [2:0] op, input logic [2:0] bk, input logic a10, input logic a12);
    @(negedge clk);
    cmdValid = v; cmdOp = op; cmdBank = bk; cmdA10 = a10; cmdA12 = a12;
    #1;
  endtask

  task automatic probe(input logic [2:0] bk);
    step(1'b0, NOP, bk, 1'b0, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) probe(3'd0);
  endtask

  task automatic t_reset;
    probe(3'd0);
    chk("R9", "bankOpen", bankOpen, 8'h00);
    chk("R9", "bankIdle", bankIdle, 8'hff);
    chk("R9", "cmdError", cmdError, 0);
    chk("R9", "lastColChop", lastColChop, 0);
    chk("R9", "okAct", okAct, 1);
    chk("R9", "okCol", okCol, 0);
    chk("R9", "okRef", okRef, 1);
    chk("R9", "okPreAll", okPreAll, 1);
  endtask

  // activate, chopped read, precharge, reactivate on bank 0
  task automatic t_row_cycle;
    step(1'b1, ACT, 3'd0, 0, 0);                       // c0
    chk("R9", "okAct before first ACT", okAct, 1);
    probe(3'd1);                                       // c1
    chk("R2", "okAct other bank inside tRRD", okAct, 0);
    chk("R10", "bankOpen after ACT", bankOpen, 8'h01);
    probe(3'd0);                                       // c2
    chk("R1", "okCol inside tRCD", okCol, 0);
    chk("R3", "okAct on open bank", okAct, 0);
    step(1'b1, RD, 3'd0, 0, 1);                        // c3 chopped read
    chk("R1", "okCol at tRCD", okCol, 1);
    probe(3'd0);                                       // c4
    chk("R7", "lastColChop after chop read", lastColChop, 1);
    probe(3'd0);                                       // c5
    probe(3'd0);                                       // c6
    chk("R7", "okCol 3 cycles after chop read", okCol, 0);
    chk("R4", "okPre inside tRAS", okPre, 0);
    probe(3'd0);                                       // c7
    chk("R7", "okCol 4 cycles after chop read", okCol, 1);
    chk("R4", "okPre one cycle before tRAS", okPre, 0);
    step(1'b1, PRE, 3'd0, 0, 0);                       // c8
    chk("R4", "okPre at tRAS", okPre, 1);
    probe(3'd0);                                       // c9
    chk("R3", "bankOpen after PRE", bankOpen[0], 0);
    chk("R10", "bankIdle while closing", bankIdle[0], 0);
    probe(3'd0);                                       // c10
    chk("R3", "okAct inside tRP", okAct, 0);
    probe(3'd0);                                       // c11
    chk("R3", "okAct at tRP", okAct, 1);
    chk("R10", "bankIdle after tRP", bankIdle[0], 1);
    chk("R8", "no error on legal traffic", cmdError, 0);
  endtask

  // read with auto-precharge where tRTP outlasts tRAS
  task automatic t_ap_read;
    step(1'b1, ACT, 3'd2, 0, 0);                       // b0
    idle(6);                                           // b1..b6
    step(1'b1, RD, 3'd2, 1, 0);                        // b7
    chk("R6", "okCol read-ap", okCol, 1);
    probe(3'd2);                                       // b8
    chk("R6", "okCol during ap wait", okCol, 0);
    probe(3'd2);                                       // b9
    chk("R6", "bankOpen until tRTP", bankOpen[2], 1);
    probe(3'd2);                                       // b10
    chk("R6", "bankOpen after closing starts", bankOpen[2], 0);
    probe(3'd2);                                       // b11
    chk("R6", "okAct before tRP after close", okAct, 0);
    probe(3'd2);                                       // b12
    chk("R6", "okAct at tRP after close", okAct, 1);
  endtask

  // write with auto-precharge where tRAS governs; tRRD exact boundary
  task automatic t_ap_write;
    step(1'b1, ACT, 3'd3, 0, 0);                       // c0
    probe(3'd4);                                       // c1
    chk("R2", "okAct other bank before tRRD", okAct, 0);
    step(1'b1, ACT, 3'd4, 0, 0);                       // c2
    chk("R2", "okAct other bank at tRRD", okAct, 1);
    step(1'b1, WR, 3'd3, 1, 0);                        // c3
    chk("R6", "okCol write-ap", okCol, 1);
    probe(3'd3);                                       // c4
    chk("R7", "lastColChop after full write", lastColChop, 0);
    chk("R10", "bankOpen in ap wait", bankOpen[3], 1);
    idle(3);                                           // c5..c7
    probe(3'd3);                                       // c8
    chk("R6", "okCol in ap wait after tCCD", okCol, 0);
    chk("R6", "bankOpen at tRAS", bankOpen[3], 1);
    probe(3'd3);                                       // c9
    chk("R6", "bankOpen after tRAS", bankOpen[3], 0);
    probe(3'd3);                                       // c10
    chk("R2", "okAct same bank before tRC", okAct, 0);
    probe(3'd3);                                       // c11
    chk("R2", "okAct same bank at tRC", okAct, 1);
  endtask

  // precharge-all then refresh; bank 4 is still open on entry
  task automatic t_refresh;
    probe(3'd0);                                       // d0
    chk("R5", "okRef with open bank", okRef, 0);
    step(1'b1, PRE, 3'd0, 1, 0);                       // d1
    chk("R4", "okPreAll", okPreAll, 1);
    probe(3'd0);                                       // d2
    chk("R4", "precharge-all closed bank 4", bankOpen, 8'h00);
    probe(3'd0);                                       // d3
    chk("R5", "okRef inside tRP", okRef, 0);
    step(1'b1, REF, 3'd0, 0, 0);                       // d4
    chk("R5", "okRef at tRP", okRef, 1);
    probe(3'd1);                                       // d5
    chk("R5", "bankIdle during refresh", bankIdle, 8'h00);
    chk("R5", "okAct during refresh", okAct, 0);
    idle(7);                                           // d6..d12
    probe(3'd1);                                       // d13
    chk("R5", "okAct before tRFC", okAct, 0);
    chk("R5", "okRef before tRFC", okRef, 0);
    probe(3'd1);                                       // d14
    chk("R5", "okAct at tRFC", okAct, 1);
    chk("R5", "okRef at tRFC", okRef, 1);
    chk("R5", "bankIdle after tRFC", bankIdle, 8'hff);
    chk("R8", "no error so far", cmdError, 0);
  endtask

  // single-bank precharge and illegal commands
  task automatic t_illegal;
    step(1'b1, ACT, 3'd5, 0, 0);                       // e0
    idle(1);                                           // e1
    step(1'b1, ACT, 3'd6, 0, 0);                       // e2
    idle(7);                                           // e3..e9
    step(1'b1, PRE, 3'd5, 0, 0);                       // e10
    probe(3'd5);                                       // e11
    chk("R4", "single precharge closed bank 5", bankOpen[5], 0);
    chk("R4", "single precharge kept bank 6", bankOpen[6], 1);
    step(1'b1, RD, 3'd5, 0, 0);                        // e12 illegal: bank closing
    probe(3'd6);                                       // e13
    chk("R8", "cmdError after illegal read", cmdError, 1);
    step(1'b1, ACT, 3'd6, 0, 0);                       // e14 illegal: bank 6 open
    probe(3'd6);                                       // e15
    chk("R8", "bank 6 still open", bankOpen[6], 1);
    chk("R8", "bank 6 column access intact", okCol, 1);
    step(1'b1, 3'd7, 3'd6, 0, 0);                      // e16 reserved op
    step(1'b1, PRE, 3'd6, 0, 0);                       // e17 legal
    probe(3'd6);                                       // e18
    chk("R8", "cmdError stays set", cmdError, 1);
    chk("R4", "legal precharge after error", bankOpen[6], 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_row_cycle();
    idle(2);
    t_ap_read();
    idle(2);
    t_ap_write();
    t_refresh();
    t_illegal();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule